// File: doc/BRIEF.md
# Prescaled Charge Accumulator Register

This block turns the signed charge pulses of a sensing front end into a 16-bit count of accumulated charge. Each strobe on the increment or decrement input is one internal charge quantum. A signed prescaler counter collects the quanta and moves the register by one count once 8·2^E quanta have gathered in one direction. E is a 3-bit exponent taken from the control register, so one register count stands for 8 to 1024 quanta.

The register starts at mid-scale because the battery state is unknown at power-up. A host can later correct it one byte at a time, normally while the shutdown bit stops the counting. An external charge-complete signal can instead set it to full scale. Counting wraps modulo 2^16, and a one-cycle flag reports each wrap in either direction. Reads are byte-wide. Reading the upper byte captures the lower byte in a shadow, so a read of the upper byte followed by the lower byte always returns one consistent value.

Top module: `charge_accum_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) acc_out is 16'h7FFF, ovf_pulse and unf_pulse are 0, and a lower-lane read returns 8'hFF.
- R2: With exponent E on psc_exp (bit 2 weighs 4, bit 1 weighs 2, bit 0 weighs 1), acc_out rises by one at the edge that takes the (8·2^E)-th increment strobe, and not before. For example, E=7 needs 1024 strobes.
- R3: Decrement strobes move acc_out down by one per 8·2^E strobes. The remainder is signed and carries across direction changes and across changes of E.
- R4: An increment and a decrement strobe in the same cycle cancel and leave the prescaler remainder unchanged.
- R5: While shutdown is 1, strobes are ignored and the remainder is held at zero, so counting after release starts from an empty prescaler.
- R6: A host write with wr_en=1 puts wr_byte into lane wr_lane (1 = bits 15:8, 0 = bits 7:0) at the next edge. The write takes priority over every other update and clears the prescaler remainder.
- R7: When pin_mode is 2'b01, a rising edge of cc_in loads 16'hFFFF at the next edge. With any other pin_mode value, cc_in has no effect.
- R8: A count up from 16'hFFFF wraps to 16'h0000, and ovf_pulse is 1 for exactly the cycle in which the wrapped value first shows.
- R9: A count down from 16'h0000 wraps to 16'hFFFF, and unf_pulse is 1 for exactly the cycle in which the wrapped value first shows.
- R10: A read with rd_lane=1 puts bits 15:8 on rd_byte one cycle later and copies bits 7:0 into a shadow. A read with rd_lane=0 returns the shadow, not the live lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_stb | input | 1 | One charge quantum in the positive direction |
| dec_stb | input | 1 | One charge quantum in the negative direction |
| psc_exp | input | 3 | Prescaler exponent E |
| shutdown | input | 1 | Stops counting and clears the prescaler |
| pin_mode | input | 2 | Alert pin mode; 2'b01 enables charge-complete |
| cc_in | input | 1 | Charge-complete input, rising edge active |
| wr_en | input | 1 | Host byte write enable |
| wr_lane | input | 1 | Byte lane for the write |
| wr_byte | input | 8 | Write data |
| rd_en | input | 1 | Host byte read enable |
| rd_lane | input | 1 | Byte lane for the read |
| acc_out | output | 16 | Accumulated charge value |
| rd_byte | output | 8 | Read data, valid the cycle after rd_en |
| ovf_pulse | output | 1 | Wrap upward flag |
| unf_pulse | output | 1 | Wrap downward flag |

## Verification
The strobe that completes a prescaler period, a host write and a charge-complete edge all change acc_out at the clock edge that samples them. The wrap flags rise at that same edge and clear one cycle later. rd_byte follows a read enable by one edge. The bench drives every input on the falling edge and samples one falling edge after the stimulus, which is the first point where each registered result is valid. For the flags it also samples the next falling edge to confirm that each pulse lasts one cycle.

// File: rtl/chgacc_pkg.sv
package chgacc_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      PIN_OFF   = 2'b00,
      PIN_CC    = 2'b01,
      PIN_ALERT = 2'b10,
      PIN_RSVD  = 2'b11
   } pin_mode_e;

   function automatic int shift_max(input int exp_w, input int base_shift);
      return (1 << exp_w) - 1 + base_shift;
   endfunction
endpackage

// File: rtl/chgacc_prescaler.sv
module chgacc_prescaler #(
   parameter int EXP_W      = 3,
   parameter int BASE_SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             step_up,
   output logic             step_dn
);
   localparam int MAX_SH = chgacc_pkg::shift_max(EXP_W, BASE_SHIFT);
   localparam int CNT_W  = MAX_SH + 2;
   localparam int SH_W   = $clog2(MAX_SH + 1);
   localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

   logic signed [CNT_W-1:0] cnt, cnt_p1, cnt_m1, lim;
   logic [SH_W-1:0]         sh;
   logic                    go_up, go_dn;

   always_comb begin
      sh      = SH_W'(exp_sel) + SH_W'(BASE_SHIFT);
      lim     = ONE <<< sh;
      go_up   = inc && !dec && !clr;
      go_dn   = dec && !inc && !clr;
      cnt_p1  = cnt + ONE;
      cnt_m1  = cnt - ONE;
      step_up = go_up && (cnt_p1 >= lim);
      step_dn = go_dn && (cnt_m1 <= -lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr || step_up || step_dn) cnt <= '0;
      else if (go_up)                          cnt <= cnt_p1;
      else if (go_dn)                          cnt <= cnt_m1;
   end
endmodule

// File: rtl/chgacc_register.sv
module chgacc_register #(
   parameter int ACC_W = 16,
   parameter int LW    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic             force_full,
   input  logic             wr_en,
   input  logic [LW-1:0]    wr_lane,
   input  logic [7:0]       wr_byte,
   output logic [ACC_W-1:0] acc,
   output logic             ovf,
   output logic             unf
);
   localparam int LANES = ACC_W / chgacc_pkg::BYTE_W;
   localparam logic [ACC_W-1:0] MID = {1'b0, {(ACC_W-1){1'b1}}};

   logic [ACC_W-1:0] base, nxt;
   logic             wrap_up, wrap_dn;

   always_comb begin
      if (force_full)   base = '1;
      else if (step_up) base = acc + ACC_W'(1);
      else if (step_dn) base = acc - ACC_W'(1);
      else              base = acc;
      wrap_up = step_up && !wr_en && !force_full && (acc == '1);
      wrap_dn = step_dn && !wr_en && !force_full && (acc == '0);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign nxt[l*8 +: 8] = (wr_en && (wr_lane == LW'(l))) ? wr_byte : base[l*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= MID;
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         acc <= nxt;
         ovf <= wrap_up;
         unf <= wrap_dn;
      end
   end
endmodule

// File: rtl/chgacc_readview.sv
module chgacc_readview #(
   parameter int ACC_W     = 16,
   parameter int LW        = 1,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [LW-1:0]    rd_lane,
   input  logic [ACC_W-1:0] acc,
   output logic [7:0]       rd_byte
);
   localparam int LANES = ACC_W / chgacc_pkg::BYTE_W;
   localparam logic [ACC_W-1:0] MID = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [LW-1:0] TOP = LW'(LANES - 1);

   logic [ACC_W-1:0] view;

   if (SHADOW_EN) begin : g_shadow
      logic [ACC_W-9:0] shadow;
      always_ff @(posedge clk) begin
         if (!rst_n)                       shadow <= MID[ACC_W-9:0];
         else if (rd_en && rd_lane == TOP) shadow <= acc[ACC_W-9:0];
      end
      assign view = {acc[ACC_W-1 -: 8], shadow};
   end else begin : g_live
      assign view = acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_byte <= '0;
      else if (rd_en) rd_byte <= view[rd_lane*8 +: 8];
   end
endmodule

// File: rtl/charge_accum_top.sv
module charge_accum_top #(
   parameter int ACC_W      = 16,
   parameter int EXP_W      = 3,
   parameter int BASE_SHIFT = 3,
   parameter bit SHADOW_EN  = 1'b1,
   localparam int LANES     = ACC_W / 8,
   localparam int LW        = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_stb,
   input  logic             dec_stb,
   input  logic [EXP_W-1:0] psc_exp,
   input  logic             shutdown,
   input  logic [1:0]       pin_mode,
   input  logic             cc_in,
   input  logic             wr_en,
   input  logic [LW-1:0]    wr_lane,
   input  logic [7:0]       wr_byte,
   input  logic             rd_en,
   input  logic [LW-1:0]    rd_lane,
   output logic [ACC_W-1:0] acc_out,
   output logic [7:0]       rd_byte,
   output logic             ovf_pulse,
   output logic             unf_pulse
);
   import chgacc_pkg::*;

   if (ACC_W < 16 || (ACC_W % BYTE_W) != 0) begin : g_bad_width
      $error("ACC_W must be a multiple of 8 and at least 16");
   end
   if (EXP_W < 1 || EXP_W > 4 || BASE_SHIFT < 0) begin : g_bad_psc
      $error("prescaler parameters out of range");
   end

   logic cc_q, cc_force, psc_clr, step_up, step_dn;

   always_ff @(posedge clk) begin
      if (!rst_n) cc_q <= 1'b0;
      else        cc_q <= cc_in;
   end

   assign cc_force = (pin_mode_e'(pin_mode) == PIN_CC) && cc_in && !cc_q;
   assign psc_clr  = shutdown || wr_en;

   chgacc_prescaler #(.EXP_W(EXP_W), .BASE_SHIFT(BASE_SHIFT)) u_psc (
      .clk(clk), .rst_n(rst_n), .clr(psc_clr), .inc(inc_stb), .dec(dec_stb),
      .exp_sel(psc_exp), .step_up(step_up), .step_dn(step_dn)
   );

   chgacc_register #(.ACC_W(ACC_W), .LW(LW)) u_reg (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .force_full(cc_force), .wr_en(wr_en), .wr_lane(wr_lane), .wr_byte(wr_byte),
      .acc(acc_out), .ovf(ovf_pulse), .unf(unf_pulse)
   );

   chgacc_readview #(.ACC_W(ACC_W), .LW(LW), .SHADOW_EN(SHADOW_EN)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_lane(rd_lane),
      .acc(acc_out), .rd_byte(rd_byte)
   );
endmodule

// File: rtl/chgacc_checker.sv
module chgacc_checker #(
   parameter int ACC_W = 16,
   parameter int EXP_W = 3,
   parameter int LW    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inc_stb,
   input logic             dec_stb,
   input logic             shutdown,
   input logic [1:0]       pin_mode,
   input logic             cc_in,
   input logic             wr_en,
   input logic [LW-1:0]    wr_lane,
   input logic [7:0]       wr_byte,
   input logic             rd_en,
   input logic [LW-1:0]    rd_lane,
   input logic [ACC_W-1:0] acc_out,
   input logic [7:0]       rd_byte,
   input logic             ovf_pulse,
   input logic             unf_pulse
);
   localparam logic [LW-1:0] TOP = LW'(ACC_W / 8 - 1);
   localparam logic [ACC_W-1:0] MID = {1'b0, {(ACC_W-1){1'b1}}};

   logic cc_armed;
   assign cc_armed = cc_in && (pin_mode == 2'b01);

   assert_midscale_after_reset_R1: assert property (@(posedge clk)
      !rst_n |=> acc_out == MID);

   assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en) && !$past(cc_armed)) |->
      (acc_out == $past(acc_out) || acc_out == $past(acc_out) + ACC_W'(1) ||
       acc_out == $past(acc_out) - ACC_W'(1)));

   assert_cancel_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(inc_stb) && $past(dec_stb) && !$past(wr_en) &&
       !$past(cc_armed)) |-> $stable(acc_out));

   assert_shutdown_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(shutdown) && !$past(wr_en) && !$past(cc_armed)) |->
      $stable(acc_out));

   assert_write_low_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lane == '0) |=> acc_out[7:0] == $past(wr_byte));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (acc_out == '0 && $past(acc_out) == '1));

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      unf_pulse |-> (acc_out == '1 && $past(acc_out) == '0));

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ovf_pulse, unf_pulse}));

   assert_upper_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_lane == TOP) |=> rd_byte == $past(acc_out[ACC_W-1 -: 8]));
endmodule

bind charge_accum_top chgacc_checker #(.ACC_W(ACC_W), .EXP_W(EXP_W), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .dec_stb(dec_stb),
   .shutdown(shutdown), .pin_mode(pin_mode), .cc_in(cc_in), .wr_en(wr_en),
   .wr_lane(wr_lane), .wr_byte(wr_byte), .rd_en(rd_en), .rd_lane(rd_lane),
   .acc_out(acc_out), .rd_byte(rd_byte), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
);

// File: tb/charge_accum_top_tb_top.sv
module charge_accum_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;
   // entry: {exponent[2:0], increments[15:0], decrements[15:0], expected acc[15:0]}
   localparam logic [50:0] VEC [NVEC] = '{
      {3'd0, 16'd8,   16'd0,  16'h8000},
      {3'd0, 16'd24,  16'd0,  16'h8003},
      {3'd1, 16'd0,   16'd32, 16'h8001},
      {3'd2, 16'd31,  16'd0,  16'h8001},
      {3'd2, 16'd1,   16'd0,  16'h8002},
      {3'd0, 16'd4,   16'd12, 16'h8001},
      {3'd3, 16'd128, 16'd0,  16'h8003}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic inc_stb = 0, dec_stb = 0, shutdown = 0, cc_in = 0;
   logic wr_en = 0, wr_lane = 0, rd_en = 0, rd_lane = 0;
   logic [2:0]  psc_exp = 3'd0;
   logic [1:0]  pin_mode = 2'b00;
   logic [7:0]  wr_byte = 8'h00;
   logic [15:0] acc_out;
   logic [7:0]  rd_byte;
   logic        ovf_pulse, unf_pulse;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   charge_accum_top dut_i (
      .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .dec_stb(dec_stb),
      .psc_exp(psc_exp), .shutdown(shutdown), .pin_mode(pin_mode), .cc_in(cc_in),
      .wr_en(wr_en), .wr_lane(wr_lane), .wr_byte(wr_byte), .rd_en(rd_en),
      .rd_lane(rd_lane), .acc_out(acc_out), .rd_byte(rd_byte),
      .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic i, input logic d);
      inc_stb = i; dec_stb = d;
      @(negedge clk);
      inc_stb = 0; dec_stb = 0;
   endtask

   task automatic run(input int ni, input int nd);
      for (int k = 0; k < ni; k++) cyc(1'b1, 1'b0);
      for (int k = 0; k < nd; k++) cyc(1'b0, 1'b1);
   endtask

   task automatic wr(input logic lane, input logic [7:0] b);
      wr_en = 1; wr_lane = lane; wr_byte = b;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic lane);
      rd_en = 1; rd_lane = lane;
      @(negedge clk);
      rd_en = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      check("R1", acc_out, 16'h7FFF);
      check("R1", {15'd0, ovf_pulse | unf_pulse}, 16'd0);
      rd(1'b0);
      check("R1", {8'd0, rd_byte}, 16'h00FF);

      // R2 / R3 table walk
      for (int v = 0; v < NVEC; v++) begin
         psc_exp = VEC[v][50:48];
         run(int'(VEC[v][47:32]), int'(VEC[v][31:16]));
         check(v < 2 ? "R2" : "R3", acc_out, VEC[v][15:0]);
      end

      // R4 cancel
      psc_exp = 3'd0;
      run(7, 0);
      for (int k = 0; k < 5; k++) cyc(1'b1, 1'b1);
      check("R4", acc_out, 16'h8003);
      run(1, 0);
      check("R4", acc_out, 16'h8004);

      // R5 shutdown
      run(5, 0);
      shutdown = 1;
      run(20, 0);
      check("R5", acc_out, 16'h8004);
      shutdown = 0;
      run(7, 0);
      check("R5", acc_out, 16'h8004);
      run(1, 0);
      check("R5", acc_out, 16'h8005);

      // R6 write lane 0, remainder cleared
      run(5, 0);
      wr(1'b0, 8'h10);
      check("R6", acc_out, 16'h8010);
      run(7, 0);
      check("R6", acc_out, 16'h8010);
      run(1, 0);
      check("R6", acc_out, 16'h8011);

      // R8 overflow
      shutdown = 1;
      wr(1'b1, 8'hFF);
      wr(1'b0, 8'hFF);
      shutdown = 0;
      check("R6", acc_out, 16'hFFFF);
      run(7, 0);
      check("R8", {15'd0, ovf_pulse}, 16'd0);
      run(1, 0);
      check("R8", acc_out, 16'h0000);
      check("R8", {15'd0, ovf_pulse}, 16'd1);
      @(negedge clk);
      check("R8", {15'd0, ovf_pulse}, 16'd0);

      // R9 underflow
      run(0, 8);
      check("R9", acc_out, 16'hFFFF);
      check("R9", {15'd0, unf_pulse}, 16'd1);
      @(negedge clk);
      check("R9", {15'd0, unf_pulse}, 16'd0);

      // R2 widest prescaler
      shutdown = 1;
      wr(1'b1, 8'h40);
      wr(1'b0, 8'h00);
      shutdown = 0;
      psc_exp = 3'd7;
      run(1023, 0);
      check("R2", acc_out, 16'h4000);
      run(1, 0);
      check("R2", acc_out, 16'h4001);

      // R7 charge complete
      pin_mode = 2'b10;
      cc_in = 1; @(negedge clk); cc_in = 0; @(negedge clk);
      check("R7", acc_out, 16'h4001);
      pin_mode = 2'b01;
      cc_in = 1; @(negedge clk);
      check("R7", acc_out, 16'hFFFF);
      cc_in = 0;

      // R10 coherent read
      shutdown = 1;
      wr(1'b1, 8'h12);
      wr(1'b0, 8'hFF);
      shutdown = 0;
      psc_exp = 3'd0;
      rd(1'b1);
      check("R10", {8'd0, rd_byte}, 16'h0012);
      run(8, 0);
      check("R10", acc_out, 16'h1300);
      rd(1'b0);
      check("R10", {8'd0, rd_byte}, 16'h00FF);
      rd(1'b1);
      check("R10", {8'd0, rd_byte}, 16'h0013);
      rd(1'b0);
      check("R10", {8'd0, rd_byte}, 16'h0000);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule